// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This controller fetches a run of 16-bit words from a small serial EEPROM with a 6-bit word address. It drives four wires: a ROM-enable line, chip select, serial clock and serial data toward the device. It also takes in the device's serial data output. A host pulses a start request with a byte start address and a byte count. The block drops bit 0 of the address to form a word address. Then it reads one word per chip-select window, until the count is used up.

Each window opens from a deselected, enabled state. Chip select rises and one idle clock pulse follows. Next comes the read opcode 110 and then the word address, both most significant bit first. Last, sixteen data bits are clocked in, also most significant bit first. Chip select then falls, the word address advances by one, and the received word goes to the host as two bytes on a byte-valid strobe, low byte first. Every half-bit phase of the serial clock lasts `CLK_MHZ * HALF_US` system cycles, so that it is at least `HALF_US` microseconds long.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, busy_o, done_o, byte_vld_o, rom_en_o, cs_o, sk_o and di_o are all 0.
- R2: A start_i pulse while idle is accepted only when count_i is nonzero and even. A zero or odd count leaves busy_o, rom_en_o and cs_o at 0 and produces no bytes.
- R3: The first word address is addr_i[6:1]. Bit 0 of addr_i is disregarded.
- R4: In every word window, chip select rises with the clock low, and exactly one clock pulse is given with di_o at 0 before the first command bit.
- R5: After that pulse, nine bits are sent most significant bit first: the opcode 110, then the 6-bit word address. di_o changes only while sk_o is low and holds steady through each high phase.
- R6: Sixteen device bits are then taken in, one per clock pulse and sampled while sk_o is high. The first bit taken is word bit 15.
- R7: Chip select drops after each word while rom_en_o stays high. The next word uses the word address plus one, wrapping from 63 to 0. Exactly count_i/2 windows are opened.
- R8: Each word is delivered as two byte_vld_o cycles in a row: bits 7:0 first, then bits 15:8.
- R9: After the last word, done_o pulses for one cycle in the same cycle that busy_o and rom_en_o fall.
- R10: sk_o changes only at the end of a full phase of CLK_MHZ*HALF_US system cycles.
- R11: cs_o changes only while sk_o is low, both before and after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a read run |
| addr_i | input | WA_W+1 | Byte start address |
| count_i | input | CNT_W | Byte count, nonzero and even |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at end of run |
| byte_o | output | 8 | Received byte |
| byte_vld_o | output | 1 | byte_o is valid this cycle |
| rom_en_o | output | 1 | EEPROM access enabled |
| cs_o | output | 1 | Chip select to the device |
| sk_o | output | 1 | Serial clock to the device |
| di_o | output | 1 | Serial data to the device |
| do_i | input | 1 | Serial data from the device |

## Verification
A stuck or miscounted bit counter in the sequencer shows up on the wires within one word window. The device model sees a wrong number of idle pulses, a wrong opcode or a shifted address at the ninth command bit, and the data that follows is misaligned. A wrong word-address register or count register shows at the next window, as an address mismatch or as an extra or missing window before done_o. A fault in the byte path is seen one or two cycles after the word completes, as a byte that differs from the scoreboard.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
  localparam int OP_W   = 3;
  localparam logic [OP_W-1:0] RD_OP = 3'b110;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EN,
    ST_CS,
    ST_DUM_H,
    ST_TX_L,
    ST_TX_H,
    ST_RX_L,
    ST_RX_H,
    ST_TAIL,
    ST_NEXT
  } ewr_state_e;
endpackage

// File: rtl/ewr_tick.sv
module ewr_tick #(
  parameter int HALF_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  // phases last at least two cycles
  p_tick_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ewr_ctrl.sv
module ewr_ctrl
  import ewr_pkg::*;
#(
  parameter int WA_W  = 6,
  parameter int CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WA_W:0]      baddr_i,
  input  logic [CNT_W-1:0]   nbytes_i,
  input  logic               tick_i,
  input  logic               do_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               rom_en_o,
  output logic               cs_o,
  output logic               sk_o,
  output logic               di_o,
  output logic [WORD_W-1:0]  word_o,
  output logic               word_vld_o
);
  localparam int TX_W = OP_W + WA_W;
  localparam int WL_W = CNT_W - 1;
  localparam int BC_W = $clog2(WORD_W);
  localparam logic [BC_W-1:0] TX_LAST = BC_W'(TX_W - 1);
  localparam logic [BC_W-1:0] RX_LAST = BC_W'(WORD_W - 1);

  ewr_state_e          st_q;
  logic [WA_W-1:0]     wa_q;
  logic [WL_W-1:0]     left_q;
  logic [BC_W-1:0]     bit_q;
  logic [TX_W-1:0]     tx_q;
  logic [WORD_W-1:0]   rx_q;
  logic                ok_req;
  logic                unused_b0;

  assign unused_b0 = baddr_i[0];
  assign ok_req    = start_i && (nbytes_i != '0) && !nbytes_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      wa_q       <= '0;
      left_q     <= '0;
      bit_q      <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      rom_en_o   <= 1'b0;
      cs_o       <= 1'b0;
      sk_o       <= 1'b0;
      di_o       <= 1'b0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      done_o     <= 1'b0;
      word_vld_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (ok_req) begin
          wa_q     <= baddr_i[WA_W:1];
          left_q   <= nbytes_i[CNT_W-1:1];
          busy_o   <= 1'b1;
          rom_en_o <= 1'b1;
          st_q     <= ST_EN;
        end
        ST_EN: if (tick_i) begin
          cs_o <= 1'b1;
          tx_q <= {RD_OP, wa_q};
          st_q <= ST_CS;
        end
        ST_CS: if (tick_i) begin
          sk_o <= 1'b1;                // idle pulse
          st_q <= ST_DUM_H;
        end
        ST_DUM_H: if (tick_i) begin
          sk_o  <= 1'b0;
          di_o  <= tx_q[TX_W-1];
          tx_q  <= tx_q << 1;
          bit_q <= '0;
          st_q  <= ST_TX_L;
        end
        ST_TX_L: if (tick_i) begin
          sk_o <= 1'b1;
          st_q <= ST_TX_H;
        end
        ST_TX_H: if (tick_i) begin
          sk_o <= 1'b0;
          if (bit_q == TX_LAST) begin
            di_o  <= 1'b0;
            bit_q <= '0;
            st_q  <= ST_RX_L;
          end else begin
            di_o  <= tx_q[TX_W-1];
            tx_q  <= tx_q << 1;
            bit_q <= bit_q + 1'b1;
            st_q  <= ST_TX_L;
          end
        end
        ST_RX_L: if (tick_i) begin
          sk_o <= 1'b1;
          st_q <= ST_RX_H;
        end
        ST_RX_H: if (tick_i) begin
          sk_o <= 1'b0;
          rx_q <= {rx_q[WORD_W-2:0], do_i};
          if (bit_q == RX_LAST) st_q <= ST_TAIL;
          else begin
            bit_q <= bit_q + 1'b1;
            st_q  <= ST_RX_L;
          end
        end
        ST_TAIL: if (tick_i) begin
          cs_o       <= 1'b0;
          word_o     <= rx_q;
          word_vld_o <= 1'b1;
          wa_q       <= wa_q + 1'b1;
          left_q     <= left_q - 1'b1;
          st_q       <= ST_NEXT;
        end
        ST_NEXT: if (tick_i) begin
          if (left_q == '0) begin
            busy_o   <= 1'b0;
            rom_en_o <= 1'b0;
            done_o   <= 1'b1;
            st_q     <= ST_IDLE;
          end else begin
            cs_o <= 1'b1;
            tx_q <= {RD_OP, wa_q};
            st_q <= ST_CS;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_di_steady_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o && $past(sk_o)) |-> $stable(di_o));
  p_cs_sk_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o != $past(cs_o)) |-> (!sk_o && !$past(sk_o)));
  p_sk_on_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o != $past(sk_o)) |-> $past(tick_i));
  p_bad_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && nbytes_i[0]) |=> !busy_o);
  p_done_at_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o && !rom_en_o));
endmodule

// File: rtl/ewr_byte_out.sv
module ewr_byte_out
  import ewr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  output logic [7:0]        byte_o,
  output logic              byte_vld_o
);
  logic [7:0] hi_q;
  logic       pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q       <= '0;
      pend_q     <= 1'b0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else if (word_vld_i) begin
      byte_o     <= word_i[7:0];
      hi_q       <= word_i[15:8];
      byte_vld_o <= 1'b1;
      pend_q     <= 1'b1;
    end else if (pend_q) begin
      byte_o     <= hi_q;
      byte_vld_o <= 1'b1;
      pend_q     <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
    end
  end

  p_lo_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_i |=> (byte_vld_o && byte_o == $past(word_i[7:0])));
  p_hi_second_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i ##1 1'b1) |=> (byte_vld_o && byte_o == $past(word_i[15:8], 2)));
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
  import ewr_pkg::*;
#(
  parameter int WA_W    = 6,
  parameter int CNT_W   = 8,
  parameter int CLK_MHZ = 200,
  parameter int HALF_US = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WA_W:0]    addr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             rom_en_o,
  output logic             cs_o,
  output logic             sk_o,
  output logic             di_o,
  input  logic             do_i
);
  // at least 3 so both bytes leave before the run ends
  localparam int HALF_CYC = (CLK_MHZ * HALF_US < 3) ? 3 : CLK_MHZ * HALF_US;

  logic              tick;
  logic [WORD_W-1:0] word;
  logic              word_vld;

  ewr_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_o),
    .tick_o (tick)
  );

  ewr_ctrl #(.WA_W(WA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .baddr_i    (addr_i),
    .nbytes_i   (count_i),
    .tick_i     (tick),
    .do_i       (do_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rom_en_o   (rom_en_o),
    .cs_o       (cs_o),
    .sk_o       (sk_o),
    .di_o       (di_o),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  ewr_byte_out u_bytes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word),
    .word_vld_i (word_vld),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o)
  );
endmodule

// File: tb/eeprom_word_reader_tb.sv
module eeprom_word_reader_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic [7:0] count_i = '0;
  logic       busy_o, done_o, byte_vld_o, rom_en_o, cs_o, sk_o, di_o;
  logic [7:0] byte_o;
  logic       dev_do = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] byte_q[$];
  logic [5:0] addr_q[$];
  int cs_rises = 0;

  always #2.5 clk_i = ~clk_i;

  eeprom_word_reader #(.CLK_MHZ(4)) u_dut (
    .clk_i, .rst_ni, .start_i, .addr_i, .count_i,
    .busy_o, .done_o, .byte_o, .byte_vld_o,
    .rom_en_o, .cs_o, .sk_o, .di_o, .do_i(dev_do)
  );

  function automatic logic [15:0] mem_word(logic [5:0] a);
    return {2'b10, a, ~a, 2'b01};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model
  logic       sk_d = 1'b0, cs_d = 1'b0;
  bit         started = 0;
  int         pre = 0, nb = 0, oc = 0;
  logic [8:0] cmd = '0;
  logic [15:0] dword = '0;
  always @(negedge clk_i) begin
    if (cs_o && !cs_d) begin
      started = 0; pre = 0; nb = 0; oc = 0; cs_rises++;
      chk(!sk_o, "R4 cs rise with clock low", sk_o, 0);
    end
    if (cs_o && sk_o && !sk_d) begin
      if (!started) begin
        if (di_o) begin
          started = 1; nb = 1; cmd = 9'b1;
          chk(pre == 1, "R4 idle pulses", pre, 1);
        end else pre++;
      end else if (nb < 9) begin
        cmd = {cmd[7:0], di_o}; nb++;
        if (nb == 9) begin
          logic [5:0] ea;
          ea = (addr_q.size() > 0) ? addr_q.pop_front() : 6'h3f;
          chk(cmd[8:6] == 3'b110, "R5 opcode", cmd[8:6], 3'b110);
          chk(cmd[5:0] == ea, "R5 R7 word address", cmd[5:0], ea);
          dword = mem_word(cmd[5:0]);
        end
      end else begin
        dev_do <= dword[15 - oc];
        oc++;
      end
    end
    sk_d = sk_o; cs_d = cs_o;
  end

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && byte_vld_o) begin
      if (byte_q.size() == 0) chk(0, "R2 R8 unexpected byte", byte_o, 0);
      else begin
        logic [7:0] e;
        e = byte_q.pop_front();
        chk(byte_o == e, "R6 R8 byte", byte_o, e);
      end
    end
  end

  task automatic run(logic [6:0] a, logic [7:0] c);
    int words;
    int base;
    bit seen;
    words = c / 2;
    for (int w = 0; w < words; w++) begin
      logic [5:0] wa;
      logic [15:0] d;
      wa = a[6:1] + 6'(w);     // R3 bit 0 dropped, R7 wraps
      d = mem_word(wa);
      addr_q.push_back(wa);
      byte_q.push_back(d[7:0]);
      byte_q.push_back(d[15:8]);
    end
    base = cs_rises;
    @(negedge clk_i);
    start_i = 1'b1; addr_i = a; count_i = c;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o && rom_en_o, "R2 accepted", busy_o, 1);
    seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk_i);
      if (done_o) seen = 1;
    end
    chk(seen, "R9 done pulse", seen, 1);
    chk(!busy_o && !rom_en_o, "R9 idle at done", busy_o, 0);
    @(negedge clk_i);
    chk(!done_o, "R9 single pulse", done_o, 0);
    chk(byte_q.size() == 0, "R8 all bytes delivered", byte_q.size(), 0);
    chk(cs_rises - base == words, "R7 window count", cs_rises - base, words);
    chk(!cs_o, "R7 deselected", cs_o, 0);
  endtask

  task automatic bad(logic [7:0] c);
    @(negedge clk_i);
    start_i = 1'b1; addr_i = 7'd10; count_i = c;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (busy_o || rom_en_o || cs_o) begin
        chk(0, "R2 ignored start", {busy_o, rom_en_o, cs_o}, 0);
        break;
      end
    end
    chk(!busy_o, "R2 ignored start", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, byte_vld_o, rom_en_o, cs_o, sk_o, di_o} == '0,
        "R1 reset outputs", {busy_o, done_o, byte_vld_o, rom_en_o, cs_o, sk_o, di_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk({busy_o, cs_o, sk_o} == '0, "R1 idle after reset", {busy_o, cs_o, sk_o}, 0);
    run(7'd0, 8'd2);
    run(7'd20, 8'd6);
    run(7'd7, 8'd2);     // R3 odd byte address
    run(7'd126, 8'd4);   // R7 wrap 63 -> 0
    bad(8'd0);
    bad(8'd5);
    run(7'd84, 8'd8);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule